// File: doc/BRIEF.md
# Partitioned SIMD Magnitude Comparator

This block compares two 64-bit operands as a set of independent lanes. The lanes are chosen at run time by a 7-bit gate mask. Each mask bit sits at the boundary between two neighbouring 8-bit slots. When the bit is set, the gate is open and the two slots join into one wider lane. The four legal groupings are eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes and one 64-bit lane.

For each lane the block reports two results: whether A is greater than B, and whether A is greater than or equal to B. Both results use the same grouping. A single select input chooses between unsigned and two's-complement comparison for all lanes at once. Each result is an 8-bit vector with one bit per slot. A lane's result bit is copied into every slot the lane covers, so a consumer can index the result by byte position whatever the lane width.

The block has no clock and no storage. One instance serves every lane width.

Top module: `part_cmp_simd`

## Requirements
- R1: Slot k is operand bits [8k+7:8k]. Gate mask bit k joins slot k and slot k+1 into the same lane when it is 1, and keeps them in separate lanes when it is 0.
- R2: With mask 7'h00, each of the eight slots is compared on its own.
- R3: With mask 7'h55 (bits 0, 2, 4 and 6 set), the operands are compared as four 16-bit lanes.
- R4: With mask 7'h77 (every bit except bit 3 set), the operands are compared as two 32-bit lanes.
- R5: With mask 7'h7F, the result equals one full 64-bit comparison, in every slot bit.
- R6: Bit i of `gt_out` is 1 exactly when A is greater than B within the lane that contains slot i.
- R7: Bit i of `ge_out` is 1 exactly when A is greater than or equal to B within the lane that contains slot i.
- R8: When `signed_sel` is 1, each lane is compared as a two's-complement number, and only the top bit of the lane is the sign bit. When `signed_sel` is 0, each lane is compared as an unsigned number.
- R9: When a lane holds equal operands, its `gt_out` bits are 0 and its `ge_out` bits are 1.
- R10: The outputs follow the inputs with no clock. A changed input is reflected in the outputs in the same cycle it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| gate_mask | input | 7 | Boundary gates. Bit k open (1) joins slot k and slot k+1 |
| signed_sel | input | 1 | 1 = two's-complement lanes, 0 = unsigned lanes |
| gt_out | output | 8 | Per-slot copy of the lane's A > B result |
| ge_out | output | 8 | Per-slot copy of the lane's A >= B result |

## Verification
Greater-than and greater-or-equal are always produced together from the same lane, and sign handling acts on the same boundaries that merging does. The stimulus therefore makes low slots tie, or differ only below a gate, and places 8'h80 and 8'h7F patterns next to open and closed gates. This exposes both the ge/gt tie split and the rule that only the lane's top bit is a sign bit. Each vector is judged against a reference that cuts every lane out as its own integer.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;
  parameter int SLOT_W  = 8;
  parameter int N_SLOTS = 8;
  localparam int DATA_W = SLOT_W * N_SLOTS;
  localparam int GATE_W = N_SLOTS - 1;

  typedef struct packed {
    logic gt;
    logic eq;
  } rel_t;
endpackage

// File: rtl/slot_rel.sv
module slot_rel
  import simd_cmp_pkg::*;
#(
  parameter int W = SLOT_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sign_top,
  output rel_t         r
);
  logic [W-1:0] a_k, b_k;

  // Flipping the sign bit of both values turns a two's-complement
  // compare into an unsigned one.
  always_comb begin
    a_k = a;
    b_k = b;
    a_k[W-1] = a[W-1] ^ sign_top;
    b_k[W-1] = b[W-1] ^ sign_top;
    r.gt = (a_k > b_k);
    r.eq = (a == b);
  end
endmodule

// File: rtl/lane_fold.sv
module lane_fold
  import simd_cmp_pkg::*;
#(
  parameter int N = N_SLOTS
) (
  input  rel_t [N-1:0] slot_r,
  input  logic [N-2:0] gate,
  output rel_t [N-1:0] acc_r
);
  // The running result moves from the top slot down to the bottom slot.
  // It crosses a boundary only where that boundary's gate is open.
  always_comb begin
    rel_t run;
    run = slot_r[N-1];
    acc_r[N-1] = run;
    for (int i = N-2; i >= 0; i--) begin
      if (gate[i]) begin
        run.gt = run.gt | (run.eq & slot_r[i].gt);
        run.eq = run.eq & slot_r[i].eq;
      end else begin
        run = slot_r[i];
      end
      acc_r[i] = run;
    end
  end
endmodule

// File: rtl/lane_spread.sv
module lane_spread
  import simd_cmp_pkg::*;
#(
  parameter int N = N_SLOTS
) (
  input  rel_t [N-1:0] acc_r,
  input  logic [N-2:0] gate,
  output logic [N-1:0] gt_v,
  output logic [N-1:0] ge_v
);
  // The finished lane result sits in the lane's lowest slot.
  // It is copied upward through each open gate.
  always_comb begin
    rel_t cur;
    cur = acc_r[0];
    gt_v[0] = cur.gt;
    ge_v[0] = cur.gt | cur.eq;
    for (int i = 1; i < N; i++) begin
      if (!gate[i-1]) cur = acc_r[i];
      gt_v[i] = cur.gt;
      ge_v[i] = cur.gt | cur.eq;
    end
  end
endmodule

// File: rtl/part_cmp_simd.sv
module part_cmp_simd
  import simd_cmp_pkg::*;
(
  input  logic [DATA_W-1:0]  opa,
  input  logic [DATA_W-1:0]  opb,
  input  logic [GATE_W-1:0]  gate_mask,
  input  logic               signed_sel,
  output logic [N_SLOTS-1:0] gt_out,
  output logic [N_SLOTS-1:0] ge_out
);
  rel_t [N_SLOTS-1:0] slot_r;
  rel_t [N_SLOTS-1:0] acc_r;

  // A slot carries its lane's sign bit only if no open gate lies above it.
  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic top_of_lane;
    if (s == N_SLOTS-1) begin : g_top
      assign top_of_lane = 1'b1;
    end else begin : g_mid
      assign top_of_lane = ~gate_mask[s];
    end
    slot_rel #(.W(SLOT_W)) u_rel (
      .a        (opa[s*SLOT_W +: SLOT_W]),
      .b        (opb[s*SLOT_W +: SLOT_W]),
      .sign_top (signed_sel & top_of_lane),
      .r        (slot_r[s])
    );
  end

  lane_fold #(.N(N_SLOTS)) u_fold (
    .slot_r (slot_r),
    .gate   (gate_mask),
    .acc_r  (acc_r)
  );

  lane_spread #(.N(N_SLOTS)) u_spread (
    .acc_r (acc_r),
    .gate  (gate_mask),
    .gt_v  (gt_out),
    .ge_v  (ge_out)
  );

  always_comb begin
    // R9: equal operands give "not greater" and "greater or equal" in every slot
    a_r9_equal_ops: assert (!(opa == opb) || (gt_out == '0 && ge_out == '1));
    // R5: a fully open mask matches one wide unsigned compare
    a_r5_full_unsigned: assert (!(gate_mask == '1 && !signed_sel) ||
                                (gt_out == {N_SLOTS{opa > opb}}));
    // R8: a fully open mask matches one wide signed compare
    a_r8_full_signed: assert (!(gate_mask == '1 && signed_sel) ||
                              (ge_out == {N_SLOTS{$signed(opa) >= $signed(opb)}}));
    for (int i = 0; i < N_SLOTS; i++) begin
      // R7: a tie seen at a slot means that slot's bytes are equal
      a_r7_tie_bytes: assert (!(ge_out[i] && !gt_out[i]) ||
                              (opa[i*SLOT_W +: SLOT_W] == opb[i*SLOT_W +: SLOT_W]));
      // R2: a fully closed mask compares each slot alone
      a_r2_solo_slot: assert (!(gate_mask == '0 && !signed_sel) ||
                              (gt_out[i] == (opa[i*SLOT_W +: SLOT_W] > opb[i*SLOT_W +: SLOT_W])));
    end
  end
endmodule

// File: tb/sim_part_cmp_simd.sv
module sim_part_cmp_simd;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [63:0] opa, opb;
  logic [6:0]  gate_mask;
  logic        signed_sel;
  logic [7:0]  gt_out, ge_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  part_cmp_simd u0 (
    .opa(opa), .opb(opb), .gate_mask(gate_mask), .signed_sel(signed_sel),
    .gt_out(gt_out), .ge_out(ge_out)
  );

  // Reference model: every lane is cut out as its own integer.
  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic [6:0] m, input logic sg,
                                output logic [7:0] egt, output logic [7:0] ege);
    int w;
    logic [63:0] lm, va, vb;
    w = (m == 7'h00) ? 8 : (m == 7'h55) ? 16 : (m == 7'h77) ? 32 : 64;
    lm = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    egt = '0;
    ege = '0;
    for (int l = 0; l < 64 / w; l++) begin
      va = (a >> (l * w)) & lm;
      vb = (b >> (l * w)) & lm;
      if (sg) begin
        va = va ^ (64'd1 << (w - 1));
        vb = vb ^ (64'd1 << (w - 1));
      end
      for (int s = (l * w) / 8; s < ((l + 1) * w) / 8; s++) begin
        egt[s] = (va > vb);
        ege[s] = (va >= vb);
      end
    end
  endfunction

  task automatic apply(input logic [63:0] a, input logic [63:0] b,
                       input logic [6:0] m, input logic sg, input string tag);
    logic [7:0] egt, ege;
    @(posedge clk);
    opa = a; opb = b; gate_mask = m; signed_sel = sg;
    model(a, b, m, sg, egt, ege);
    @(negedge clk);
    n_vec++;
    if (gt_out !== egt || ge_out !== ege) begin
      n_bad++;
      $display("FAIL %s: mask=%h sgn=%0d a=%h b=%h gt=%h ge=%h expected gt=%h ge=%h",
               tag, m, sg, a, b, gt_out, ge_out, egt, ege);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    logic [6:0] masks [4];
    string      tags  [4];
    logic [63:0] a, b;
    masks[0] = 7'h00; tags[0] = "R2 R1 R6 R7";
    masks[1] = 7'h55; tags[1] = "R3 R6 R7";
    masks[2] = 7'h77; tags[2] = "R4 R6 R7";
    masks[3] = 7'h7F; tags[3] = "R5 R6 R7";
    opa = '0; opb = '0; gate_mask = '0; signed_sel = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: zero operands, all slots tie (R9)
    apply(64'd0, 64'd0, 7'h00, 1'b0, "R9 idle");
    apply(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 7'h7F, 1'b1, "R9 equal");
    // Borrow across a slot boundary (R5, R1)
    apply(64'h0000_0000_0000_0100, 64'h0000_0000_0000_00FF, 7'h7F, 1'b0, "R5 carry");
    apply(64'h0000_0000_0000_0100, 64'h0000_0000_0000_00FF, 7'h00, 1'b0, "R2 split");
    // Sign bit only at the top of a lane (R8)
    apply(64'h0000_0000_0000_0080, 64'h0000_0000_0000_007F, 7'h00, 1'b1, "R8 byte sign");
    apply(64'h0000_0000_0000_0080, 64'h0000_0000_0000_007F, 7'h7F, 1'b1, "R8 inner bit");
    apply(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 7'h7F, 1'b1, "R8 wide sign");
    apply(64'h0000_0080_0000_0000, 64'h0000_007F_0000_0000, 7'h77, 1'b1, "R8 R4 lane");
    apply(64'h0000_8000_0000_0000, 64'h0000_7FFF_0000_0000, 7'h55, 1'b1, "R8 R3 lane");
    // Back-to-back changes, judged in the cycle they are applied (R10)
    apply(64'hFF, 64'h00, 7'h00, 1'b0, "R10 step up");
    apply(64'h00, 64'hFF, 7'h00, 1'b0, "R10 step down");

    for (int k = 0; k < 4; k++) begin
      for (int sg = 0; sg < 2; sg++) begin
        for (int v = 0; v < 250; v++) begin
          a = rnd64();
          b = a;
          // Change only a few bytes so ties in the upper slots are common.
          for (int s = 0; s < 8; s++)
            if ($urandom_range(3) == 0) b[s*8 +: 8] = 8'($urandom());
          if (v % 5 == 0) b = rnd64();
          apply(a, b, masks[k], sg[0], sg[0] ? {tags[k], " R8"} : tags[k]);
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule